// File: doc/BRIEF.md
# Real-Time Clock Control, Charger Key and Oscillator-Stop Flag

This block holds three configuration and status bytes of a serial real-time clock: a control byte, a trickle-charger configuration byte and a flag byte. Software writes the bytes through a simple strobe, select and data interface, and reads them back as parallel bytes. The control byte drives an open-drain test pin. The pin carries either a 512 Hz square wave or a static level. The control byte also supplies the calibration sign and magnitude to a trim circuit outside the block.

The charger byte is decoded into one-hot resistor enables. Charging is allowed only when the upper six bits form an exact key. A free-running reference counts how long the oscillator-alive input stays low. Once it has been low for a programmable interval, a sticky stop flag sets. Software clears the flag by writing zero to it.

Top module: `rtc_ctl_status`

## Requirements
- R1: After reset the control byte reads 80h, the charger byte reads 00h, the flag byte reads 80h (stop flag set), the pin is released and no resistor enable is active.
- R2: A write with select 0 loads the control byte, which reads back in full. Bit 5 appears on `cal_neg` and bits 4:0 appear on `cal_mag`.
- R3: While control bit 6 is 0, `pin_pull_low` is the inverse of control bit 7: it pulls low when that bit is 0 and releases when it is 1.
- R4: While control bit 6 is 1, `pin_pull_low` is the inverse of an internal square wave. The wave is 0 after reset and inverts on every cycle in which `sq_tick` is high, whatever the state of bit 6.
- R5: A write with select 1 loads the charger byte, which reads back in full. `res_en` is one-hot: bit 0 when the byte is A5h, bit 1 for A6h and bit 2 for A7h. Any other value gives zero.
- R6: The flag byte reads as {stop flag, 0000000}, and written values of bits 6:0 never appear.
- R7: The stop flag sets at the clock edge where `osc_alive` has been sampled low on STOP_CYCLES consecutive edges, and not earlier.
- R8: A write with select 2 and data bit 7 equal to 0 clears the stop flag. A write with data bit 7 equal to 1 leaves it unchanged.
- R9: While `osc_alive` has been low for at least STOP_CYCLES edges, the stop flag stays set even when a clear is written.
- R10: A write with select 3 changes no byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock, also the stop-timer time base |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 control, 1 charger, 2 flag, 3 none |
| wr_data | input | 8 | Write data |
| sq_tick | input | 1 | Half-period pulse of the 512 Hz square wave |
| osc_alive | input | 1 | High while the oscillator runs (synchronous to clk) |
| ctl_q | output | 8 | Control byte readback |
| chg_q | output | 8 | Charger byte readback |
| flag_q | output | 8 | Flag byte readback |
| pin_pull_low | output | 1 | 1 pulls the open-drain test pin low, 0 releases it |
| res_en | output | 3 | One-hot charger resistor enables (low, mid, high value) |
| cal_neg | output | 1 | Calibration sign |
| cal_mag | output | 5 | Calibration magnitude |

## Verification
Every output is combinational from registers. A write, a tick or an `osc_alive` sample therefore takes effect on the rising edge that samples it, and shows at the ports before the next edge. The bench drives each stimulus at a falling edge and lets one rising edge pass. It compares all outputs at the following falling edge against its own cycle model, and does this for every step. The stop flag is due on the STOP_CYCLES-th consecutive low sample, so directed runs hold `osc_alive` low for one sample fewer and check the flag is still clear, then for one more sample and check it is set.

// File: rtl/rtc_ctl_pkg.sv
package rtc_ctl_pkg;
   typedef enum logic [1:0] {
      SEL_CTL  = 2'd0,
      SEL_CHG  = 2'd1,
      SEL_FLAG = 2'd2,
      SEL_NONE = 2'd3
   } reg_sel_e;

   localparam int unsigned BYTE_W   = 8;
   localparam int unsigned CAL_W    = 5;
   localparam int unsigned N_RES    = 3;
   localparam logic [7:0]  CTL_RST  = 8'h80;
   localparam logic [7:0]  CHG_RST  = 8'h00;
endpackage

// File: rtl/rtc_ctl_byte.sv
module rtc_ctl_byte
   import rtc_ctl_pkg::*;
#(
   parameter logic [BYTE_W-1:0] RST_VAL = CTL_RST
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [BYTE_W-1:0] din,
   input  logic              sq_tick,
   output logic [BYTE_W-1:0] q,
   output logic              pin_pull_low,
   output logic              cal_neg,
   output logic [CAL_W-1:0]  cal_mag
);
   logic [BYTE_W-1:0] ctl_r;
   logic              sq_r;
   logic              sel_level;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctl_r <= RST_VAL;
         sq_r  <= 1'b0;
      end else begin
         if (wr)      ctl_r <= din;
         if (sq_tick) sq_r  <= ~sq_r;
      end
   end

   always_comb begin
      sel_level = ctl_r[6] ? sq_r : ctl_r[7];
   end

   assign pin_pull_low = ~sel_level;
   assign q            = ctl_r;
   assign cal_neg      = ctl_r[5];
   assign cal_mag      = ctl_r[CAL_W-1:0];

   a_r3_static_level: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && !din[6]) |=> (pin_pull_low == !$past(din[7])));

   a_r4_square_flips: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_r[6] && sq_tick && !wr) |=> (pin_pull_low != $past(pin_pull_low)));
endmodule

// File: rtl/rtc_chg_cfg.sv
module rtc_chg_cfg
   import rtc_ctl_pkg::*;
#(
   parameter logic [3:0] KEY_HI  = 4'hA,
   parameter logic [1:0] KEY_MID = 2'b01
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [BYTE_W-1:0] din,
   output logic [BYTE_W-1:0] q,
   output logic [N_RES-1:0]  res_en
);
   localparam int unsigned CODE_W = $clog2(N_RES + 1);

   logic [BYTE_W-1:0] chg_r;
   logic              key_ok;

   always_ff @(posedge clk) begin
      if (!rst_n)  chg_r <= CHG_RST;
      else if (wr) chg_r <= din;
   end

   assign key_ok = (chg_r[7:4] == KEY_HI) && (chg_r[3:2] == KEY_MID);
   assign q      = chg_r;

   for (genvar g = 0; g < N_RES; g++) begin : g_res
      assign res_en[g] = key_ok && (chg_r[CODE_W-1:0] == CODE_W'(g + 1));
   end

   a_r5_enable_needs_key: assert property (@(posedge clk) disable iff (!rst_n)
      (res_en != '0) |-> (q[7:2] == {KEY_HI, KEY_MID}));

   a_r5_enable_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(res_en));
endmodule

// File: rtl/rtc_osc_flag.sv
module rtc_osc_flag
   import rtc_ctl_pkg::*;
#(
   parameter int unsigned STOP_CYCLES = 3276800
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [BYTE_W-1:0] din,
   input  logic              osc_alive,
   output logic [BYTE_W-1:0] q
);
   localparam int unsigned CW  = (STOP_CYCLES > 2) ? $clog2(STOP_CYCLES) : 1;
   localparam logic [CW-1:0] LIM = CW'(STOP_CYCLES - 1);

   if (STOP_CYCLES < 2) begin : g_bad_limit
      $error("rtc_osc_flag: STOP_CYCLES must be at least 2");
   end

   logic [CW-1:0] low_cnt;
   logic          osf_r;
   logic          stop_hit;
   logic          clr_req;

   assign stop_hit = !osc_alive && (low_cnt == LIM);
   assign clr_req  = wr && !din[7];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         low_cnt <= '0;
         osf_r   <= 1'b1;
      end else begin
         if (osc_alive)            low_cnt <= '0;
         else if (low_cnt != LIM)  low_cnt <= low_cnt + 1'b1;

         if (stop_hit)     osf_r <= 1'b1;
         else if (clr_req) osf_r <= 1'b0;
      end
   end

   assign q = {osf_r, {(BYTE_W-1){1'b0}}};

   a_r7_no_early_set: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(osf_r) |-> ($past(low_cnt) == LIM && !$past(osc_alive)));

   a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (osf_r && !clr_req) |=> osf_r);

   a_r8_one_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (!osf_r && !stop_hit) |=> !osf_r);

   a_r9_hold_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
      stop_hit |=> osf_r);
endmodule

// File: rtl/rtc_ctl_status.sv
module rtc_ctl_status
   import rtc_ctl_pkg::*;
#(
   parameter int unsigned STOP_CYCLES = 3276800
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_en,
   input  logic [1:0] wr_sel,
   input  logic [7:0] wr_data,
   input  logic       sq_tick,
   input  logic       osc_alive,
   output logic [7:0] ctl_q,
   output logic [7:0] chg_q,
   output logic [7:0] flag_q,
   output logic       pin_pull_low,
   output logic [2:0] res_en,
   output logic       cal_neg,
   output logic [4:0] cal_mag
);
   logic wr_ctl, wr_chg, wr_flag;

   assign wr_ctl  = wr_en && (wr_sel == SEL_CTL);
   assign wr_chg  = wr_en && (wr_sel == SEL_CHG);
   assign wr_flag = wr_en && (wr_sel == SEL_FLAG);

   rtc_ctl_byte u_ctl (
      .clk          (clk),
      .rst_n        (rst_n),
      .wr           (wr_ctl),
      .din          (wr_data),
      .sq_tick      (sq_tick),
      .q            (ctl_q),
      .pin_pull_low (pin_pull_low),
      .cal_neg      (cal_neg),
      .cal_mag      (cal_mag)
   );

   rtc_chg_cfg u_chg (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr     (wr_chg),
      .din    (wr_data),
      .q      (chg_q),
      .res_en (res_en)
   );

   rtc_osc_flag #(.STOP_CYCLES(STOP_CYCLES)) u_flag (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr        (wr_flag),
      .din       (wr_data),
      .osc_alive (osc_alive),
      .q         (flag_q)
   );

   a_r10_none_select: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel == SEL_NONE) |=> ($stable(ctl_q) && $stable(chg_q)));
endmodule

// File: tb/rtc_ctl_status_tb.sv
module rtc_ctl_status_tb;
   localparam int unsigned STOP = 20;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [1:0] wr_sel = 2'd0;
   logic [7:0] wr_data = 8'h00;
   logic       sq_tick = 1'b0;
   logic       osc_alive = 1'b1;
   logic [7:0] ctl_q, chg_q, flag_q;
   logic       pin_pull_low;
   logic [2:0] res_en;
   logic       cal_neg;
   logic [4:0] cal_mag;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;
   string tag = "R1";

   logic [7:0] m_ctl = 8'h80, m_chg = 8'h00;
   logic       m_osf = 1'b1, m_sq = 1'b0;
   int         m_low = 0;

   always #5 clk = ~clk;

   rtc_ctl_status #(.STOP_CYCLES(STOP)) u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
      .wr_data(wr_data), .sq_tick(sq_tick), .osc_alive(osc_alive),
      .ctl_q(ctl_q), .chg_q(chg_q), .flag_q(flag_q),
      .pin_pull_low(pin_pull_low), .res_en(res_en),
      .cal_neg(cal_neg), .cal_mag(cal_mag)
   );

   function automatic logic [2:0] exp_res(input logic [7:0] c);
      if (c[7:2] == 6'b101001 && c[1:0] != 2'b00) return 3'b001 << (c[1:0] - 2'd1);
      return 3'b000;
   endfunction

   function automatic logic exp_pin(input logic [7:0] c, input logic sq);
      return c[6] ? !sq : !c[7];
   endfunction

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic compare_all();
      chk("R2", "ctl_q", ctl_q, m_ctl);
      chk("R2", "cal", {cal_neg, cal_mag}, m_ctl[5:0]);
      chk("R5", "chg_q", chg_q, m_chg);
      chk("R5", "res_en", res_en, exp_res(m_chg));
      chk(tag, "flag_q", flag_q, {m_osf, 7'b0});
      chk(m_ctl[6] ? "R4" : "R3", "pin", pin_pull_low, exp_pin(m_ctl, m_sq));
   endtask

   task automatic step(input bit we, input bit [1:0] sel, input bit [7:0] d,
                       input bit tk, input bit alive);
      bit set_now;
      wr_en = we; wr_sel = sel; wr_data = d; sq_tick = tk; osc_alive = alive;
      @(posedge clk);
      if (we && sel == 2'd0) m_ctl = d;
      if (we && sel == 2'd1) m_chg = d;
      set_now = !alive && (m_low == STOP - 1);
      if (alive) m_low = 0;
      else if (m_low != STOP - 1) m_low++;
      if (set_now) m_osf = 1'b1;
      else if (we && sel == 2'd2 && !d[7]) m_osf = 1'b0;
      if (tk) m_sq = !m_sq;
      @(negedge clk);
      wr_en = 1'b0; sq_tick = 1'b0;
      compare_all();
   endtask

   initial begin
      #1500000;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      void'($urandom(32'd1340));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      tag = "R1";
      chk("R1", "reset ctl", ctl_q, 8'h80);
      chk("R1", "reset chg", chg_q, 8'h00);
      chk("R1", "reset flag", flag_q, 8'h80);
      chk("R1", "reset pin", pin_pull_low, 0);
      chk("R1", "reset res_en", res_en, 0);

      tag = "R6 R8";
      step(1, 2'd0, 8'h00, 0, 1);   // R3 pin pulls low
      step(1, 2'd0, 8'hB7, 0, 1);   // R2 cal fields, R3 released
      step(1, 2'd0, 8'h40, 0, 1);   // R4 square mode
      for (int i = 0; i < 6; i++) step(0, 2'd0, 8'h00, 1, 1);
      step(1, 2'd1, 8'hA5, 0, 1);   // R5
      step(1, 2'd1, 8'hA6, 0, 1);
      step(1, 2'd1, 8'hA7, 0, 1);
      step(1, 2'd1, 8'hA4, 0, 1);
      step(1, 2'd1, 8'hB5, 0, 1);
      step(1, 2'd1, 8'hA1, 0, 1);
      step(1, 2'd1, 8'hA6, 0, 1);
      tag = "R10";
      step(1, 2'd3, 8'h00, 0, 1);
      step(1, 2'd3, 8'hFF, 0, 1);
      tag = "R6 R8";
      step(1, 2'd2, 8'h7F, 0, 1);   // clear, lower bits stay 0
      step(1, 2'd2, 8'hFF, 0, 1);   // write of 1 ignored
      tag = "R7";
      for (int i = 0; i < STOP - 1; i++) step(0, 2'd0, 8'h00, 0, 0);
      step(0, 2'd0, 8'h00, 0, 0);   // sets here
      tag = "R9";
      step(1, 2'd2, 8'h00, 0, 0);
      step(1, 2'd2, 8'h00, 0, 0);
      tag = "R8";
      step(1, 2'd2, 8'h00, 0, 1);
      tag = "R7";
      for (int i = 0; i < STOP - 1; i++) step(0, 2'd0, 8'h00, 0, 0);
      step(0, 2'd0, 8'h00, 0, 1);   // one short: stays clear

      tag = "R6 R7 R8 R9";
      for (int i = 0; i < 3000; i++) begin
         bit alive;
         bit [7:0] d;
         alive = !(((i / 150) % 2 == 1) && ((i % 150) < (10 + (i / 300) % 25)));
         d = $urandom;
         if ($urandom % 4 == 0) d = {6'b101001, d[1:0]};
         step(($urandom % 3) == 0, 2'($urandom), d, ($urandom % 2) == 0, alive);
      end

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule